// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation cache that maps a 32-bit virtual address onto a physical address using 256-byte pages. Every stored entry carries an 8-bit address-space tag next to its virtual page number. A lookup only matches entries whose tag equals the current process identifier presented on `curPid`. Because of this, an operating system can switch between processes without discarding the cached translations.

A lookup is strobed with `lookupValid`. Its result (hit, physical address, or a walk request carrying the missing page number) is registered and appears one cycle later. When translation is disabled, or the address lies in the top eighth of the address space, the address passes through unchanged. That top window is where the page tables live. After a miss, an external walker writes the new translation through the refill port. Software-directed invalidation can clear one slot, every slot of one address space, or the whole buffer.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, and `respValid`, `respHit` and `walkReq` are low; a translated lookup issued right after reset misses.
- R2: A virtual address splits into a 24-bit page number (bits 31:8) and an 8-bit offset (bits 7:0). A lookup strobed on one rising edge produces `respValid` high for exactly the following cycle, and `respValid` is low in any cycle that does not follow a strobe.
- R3: When `mmuEnable` is low, or address bits 31:29 are 3'b111, the response has `respHit`=1, `respPaddr` equal to the virtual address and `walkReq`=0, whatever the buffer contains.
- R4: On a hit, `respPaddr` is the stored 24-bit physical page number concatenated with the unchanged 8-bit offset, and `respHit`=1.
- R5: An entry matches only if it is valid, its page number equals the address page number, and its stored tag equals `curPid`; the same page number under another identifier misses.
- R6: A translated miss gives `respHit`=0, `respPaddr`=0, `walkReq`=1 for that one response cycle and `walkVpn` equal to the missing page number.
- R7: The buffer holds eight entries. A refill whose page number and tag are already present overwrites that entry in place. Otherwise the refill takes the lowest-numbered invalid slot.
- R8: A refill into a full buffer with no matching entry replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping after slot 7, only on such replacements.
- R9: `invValid` with `invOp`=1 clears the entry in slot `invIndex`; other entries are untouched.
- R10: `invValid` with `invOp`=2 clears, in one cycle, every entry whose tag equals `invAsid`; entries of other identifiers still hit.
- R11: `invValid` with `invOp`=3 clears all entries; `invOp`=0 has no effect on the contents.
- R12: A lookup in the same cycle as a refill or invalidation sees the contents before that write; the change is visible to lookups from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| mmuEnable | input | 1 | Translation enable; low means identity mapping |
| curPid | input | 8 | Identifier of the running process |
| lookupValid | input | 1 | Lookup strobe |
| lookupVaddr | input | 32 | Virtual address to translate |
| refillValid | input | 1 | Write a new translation |
| refillVpn | input | 24 | Page number of the translation |
| refillAsid | input | 8 | Address-space tag of the translation |
| refillPpn | input | 24 | Physical page number of the translation |
| invValid | input | 1 | Invalidation strobe |
| invOp | input | 2 | 0 none, 1 one slot, 2 by tag, 3 all |
| invIndex | input | 3 | Slot cleared by operation 1 |
| invAsid | input | 8 | Tag cleared by operation 2 |
| respValid | output | 1 | Result of the previous cycle's lookup is present |
| respHit | output | 1 | Translation found or bypassed |
| respPaddr | output | 32 | Physical address (0 on a miss) |
| walkReq | output | 1 | Miss pulse for the table walker |
| walkVpn | output | 24 | Page number the walker must fetch |

## Verification
The checker watches, on every cycle, the one-cycle response timing, the fact that a walk request only ever comes with a miss and names the looked-up page, the offset passing through on hits, the identity mapping while translation is off, and misses right after a full flush. Placement and eviction depend on the history of refills and invalidations, so only the bench's scenarios can show them. These are in-place overwrite, preference for free slots, round-robin order, selective clearing by slot or by tag, and tag isolation between processes. The bench checks these against a reference model that it updates at each refill and invalidation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Invalidation operation encoding at the block edge
  localparam logic [1:0] INV_NONE  = 2'd0;
  localparam logic [1:0] INV_SLOT  = 2'd1;
  localparam logic [1:0] INV_TAG   = 2'd2;
  localparam logic [1:0] INV_FLUSH = 2'd3;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic lookupFire;
    logic lookupBypass;
    logic refillWe;
    logic clrSlot;
    logic clrTag;
    logic clrAll;
  } tlbStrobes_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int ENTRIES  = 8,
  parameter int BYPASS_W = 3,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mmuEnable,
  input  logic               lookupValid,
  input  logic [VA_W-1:0]    lookupVaddr,
  input  logic               refillValid,
  input  logic               invValid,
  input  logic [1:0]         invOp,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] refillHitVec,
  output tlbStrobes_t        strobes,
  output logic [IDX_W-1:0]   victimSlot
);

  logic [IDX_W-1:0] rrQ;
  logic [IDX_W-1:0] matchSlot;
  logic [IDX_W-1:0] freeSlot;
  logic             anyMatch;
  logic             anyFree;
  logic             inBypassWindow;

  assign inBypassWindow = &lookupVaddr[VA_W-1 -: BYPASS_W];

  always_comb begin
    strobes              = '0;
    strobes.lookupFire   = lookupValid;
    strobes.lookupBypass = !mmuEnable || inBypassWindow;
    strobes.refillWe     = refillValid;
    strobes.clrSlot      = invValid && (invOp == INV_SLOT);
    strobes.clrTag       = invValid && (invOp == INV_TAG);
    strobes.clrAll       = invValid && (invOp == INV_FLUSH);
  end

  // Lowest-index matching slot and lowest-index free slot
  always_comb begin
    matchSlot = '0;
    anyMatch  = 1'b0;
    freeSlot  = '0;
    anyFree   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (refillHitVec[i]) begin
        matchSlot = IDX_W'(i);
        anyMatch  = 1'b1;
      end
      if (!validVec[i]) begin
        freeSlot = IDX_W'(i);
        anyFree  = 1'b1;
      end
    end
  end

  always_comb begin
    if (anyMatch)     victimSlot = matchSlot;
    else if (anyFree) victimSlot = freeSlot;
    else              victimSlot = rrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrQ <= '0;
    end else if (refillValid && !anyMatch && !anyFree) begin
      rrQ <= (rrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrQ + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PAGE_W   = 8,
  parameter int ASID_W   = 8,
  parameter int ENTRIES  = 8,
  localparam int VPN_W   = VA_W - PAGE_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobes_t        strobes,
  input  logic [IDX_W-1:0]   victimSlot,
  input  logic [ASID_W-1:0]  curPid,
  input  logic [VA_W-1:0]    lookupVaddr,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [ASID_W-1:0]  refillAsid,
  input  logic [VPN_W-1:0]   refillPpn,
  input  logic [IDX_W-1:0]   invIndex,
  input  logic [ASID_W-1:0]  invAsid,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] refillHitVec,
  output logic               respValid,
  output logic               respHit,
  output logic [VA_W-1:0]    respPaddr,
  output logic               walkReq,
  output logic [VPN_W-1:0]   walkVpn
);

  logic [VPN_W-1:0]   lookupVpn;
  logic [ENTRIES-1:0] lookupHitVec;
  logic [VPN_W-1:0]   entryPpn [ENTRIES];
  logic [VPN_W-1:0]   readPpn;
  logic               anyHit;

  assign lookupVpn = lookupVaddr[VA_W-1:PAGE_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic              validQ;
    logic [VPN_W-1:0]  vpnQ;
    logic [ASID_W-1:0] asidQ;
    logic [VPN_W-1:0]  ppnQ;
    logic              clearHere;
    logic              writeHere;

    assign clearHere = strobes.clrAll
                    || (strobes.clrTag  && (asidQ == invAsid))
                    || (strobes.clrSlot && (invIndex == IDX_W'(g)));
    assign writeHere = strobes.refillWe && (victimSlot == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        vpnQ   <= '0;
        asidQ  <= '0;
        ppnQ   <= '0;
      end else begin
        if (clearHere) validQ <= 1'b0;
        if (writeHere) begin
          validQ <= 1'b1;
          vpnQ   <= refillVpn;
          asidQ  <= refillAsid;
          ppnQ   <= refillPpn;
        end
      end
    end

    assign validVec[g]     = validQ;
    assign entryPpn[g]     = ppnQ;
    assign lookupHitVec[g] = validQ && (vpnQ == lookupVpn) && (asidQ == curPid);
    assign refillHitVec[g] = validQ && (vpnQ == refillVpn) && (asidQ == refillAsid);
  end

  // Entries are unique per (page, tag), so at most one hit: OR-select
  always_comb begin
    readPpn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupHitVec[i]) readPpn = readPpn | entryPpn[i];
    end
  end

  assign anyHit = |lookupHitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPaddr <= '0;
      walkReq   <= 1'b0;
      walkVpn   <= '0;
    end else begin
      respValid <= strobes.lookupFire;
      walkReq   <= 1'b0;
      respHit   <= 1'b0;
      if (strobes.lookupFire) begin
        if (strobes.lookupBypass) begin
          respHit   <= 1'b1;
          respPaddr <= lookupVaddr;
        end else if (anyHit) begin
          respHit   <= 1'b1;
          respPaddr <= {readPpn, lookupVaddr[PAGE_W-1:0]};
        end else begin
          respPaddr <= '0;
          walkReq   <= 1'b1;
          walkVpn   <= lookupVpn;
        end
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PAGE_W   = 8,
  parameter int ASID_W   = 8,
  parameter int ENTRIES  = 8,
  parameter int BYPASS_W = 3,
  localparam int VPN_W   = VA_W - PAGE_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mmuEnable,
  input  logic [ASID_W-1:0] curPid,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic              refillValid,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [ASID_W-1:0] refillAsid,
  input  logic [VPN_W-1:0]  refillPpn,
  input  logic              invValid,
  input  logic [1:0]        invOp,
  input  logic [IDX_W-1:0]  invIndex,
  input  logic [ASID_W-1:0] invAsid,
  output logic              respValid,
  output logic              respHit,
  output logic [VA_W-1:0]   respPaddr,
  output logic              walkReq,
  output logic [VPN_W-1:0]  walkVpn
);

  tlbStrobes_t        strobes;
  logic [IDX_W-1:0]   victimSlot;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] refillHitVec;

  tlb_ctrl #(
    .VA_W(VA_W), .ENTRIES(ENTRIES), .BYPASS_W(BYPASS_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .mmuEnable(mmuEnable),
    .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .refillValid(refillValid), .invValid(invValid), .invOp(invOp),
    .validVec(validVec), .refillHitVec(refillHitVec),
    .strobes(strobes), .victimSlot(victimSlot)
  );

  tlb_datapath #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .ASID_W(ASID_W), .ENTRIES(ENTRIES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .victimSlot(victimSlot),
    .curPid(curPid), .lookupVaddr(lookupVaddr),
    .refillVpn(refillVpn), .refillAsid(refillAsid), .refillPpn(refillPpn),
    .invIndex(invIndex), .invAsid(invAsid),
    .validVec(validVec), .refillHitVec(refillHitVec),
    .respValid(respValid), .respHit(respHit), .respPaddr(respPaddr),
    .walkReq(walkReq), .walkVpn(walkVpn)
  );

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int VA_W     = 32,
  parameter int PAGE_W   = 8,
  parameter int ASID_W   = 8,
  parameter int ENTRIES  = 8,
  parameter int BYPASS_W = 3,
  localparam int VPN_W   = VA_W - PAGE_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              mmuEnable,
  input logic [ASID_W-1:0] curPid,
  input logic              lookupValid,
  input logic [VA_W-1:0]   lookupVaddr,
  input logic              refillValid,
  input logic [VPN_W-1:0]  refillVpn,
  input logic [ASID_W-1:0] refillAsid,
  input logic [VPN_W-1:0]  refillPpn,
  input logic              invValid,
  input logic [1:0]        invOp,
  input logic [IDX_W-1:0]  invIndex,
  input logic [ASID_W-1:0] invAsid,
  input logic              respValid,
  input logic              respHit,
  input logic [VA_W-1:0]   respPaddr,
  input logic              walkReq,
  input logic [VPN_W-1:0]  walkVpn
);

  a_r2_resp_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  a_r6_walk_only_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> (respValid && !respHit && (respPaddr == '0)));

  a_r6_walk_names_page: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> (walkVpn == $past(lookupVaddr[VA_W-1:PAGE_W])));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> (respPaddr[PAGE_W-1:0] == $past(lookupVaddr[PAGE_W-1:0])));

  a_r3_identity_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !mmuEnable) |=> (respHit && !walkReq && (respPaddr == $past(lookupVaddr))));

  a_r11_flush_then_miss: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && (invOp == 2'd3) && !refillValid) ##1
    (lookupValid && mmuEnable && !(&lookupVaddr[VA_W-1 -: BYPASS_W])) |=> !respHit);

endmodule

bind asid_tlb tlb_checker #(
  .VA_W(VA_W), .PAGE_W(PAGE_W), .ASID_W(ASID_W),
  .ENTRIES(ENTRIES), .BYPASS_W(BYPASS_W)
) uChecker (.*);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mmuEnable = 1'b1;
  logic [7:0]  curPid = '0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic        refillValid = 1'b0;
  logic [23:0] refillVpn = '0;
  logic [7:0]  refillAsid = '0;
  logic [23:0] refillPpn = '0;
  logic        invValid = 1'b0;
  logic [1:0]  invOp = '0;
  logic [2:0]  invIndex = '0;
  logic [7:0]  invAsid = '0;
  logic        respValid, respHit, walkReq;
  logic [31:0] respPaddr;
  logic [23:0] walkVpn;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asid_tlb dut (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model
  bit         mV   [NSLOT];
  logic [23:0] mVpn [NSLOT];
  logic [7:0]  mAsid[NSLOT];
  logic [23:0] mPpn [NSLOT];
  int          mRr = 0;

  // Scoreboard queues
  logic        qHit [$];
  logic [31:0] qPa  [$];
  logic        qWalk[$];
  logic [23:0] qWvpn[$];
  string       qTag [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expectLookup(input logic [31:0] va, input string tag);
    logic hit;
    logic [31:0] pa;
    hit = 1'b0;
    pa  = '0;
    if (!mmuEnable || va[31:29] == 3'b111) begin
      hit = 1'b1;
      pa  = va;
    end else begin
      for (int i = 0; i < NSLOT; i++)
        if (mV[i] && mVpn[i] == va[31:8] && mAsid[i] == curPid) begin
          hit = 1'b1;
          pa  = {mPpn[i], va[7:0]};
        end
    end
    qHit.push_back(hit);
    qPa.push_back(pa);
    qWalk.push_back(!hit);
    qWvpn.push_back(va[31:8]);
    qTag.push_back(tag);
  endtask

  task automatic modelInv(input logic [1:0] op, input int idx, input logic [7:0] asid);
    for (int i = 0; i < NSLOT; i++) begin
      if (op == 2'd3) mV[i] = 1'b0;
      if (op == 2'd2 && mAsid[i] == asid) mV[i] = 1'b0;
      if (op == 2'd1 && i == idx) mV[i] = 1'b0;
    end
  endtask

  task automatic modelRefill(input logic [23:0] vpn, input logic [7:0] asid,
                             input logic [23:0] ppn);
    int slot;
    slot = -1;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (mV[i] && mVpn[i] == vpn && mAsid[i] == asid) slot = i;
    if (slot < 0)
      for (int i = NSLOT - 1; i >= 0; i--)
        if (!mV[i]) slot = i;
    if (slot < 0) begin
      slot = mRr;
      mRr  = (mRr + 1) % NSLOT;
    end
    mV[slot] = 1'b1; mVpn[slot] = vpn; mAsid[slot] = asid; mPpn[slot] = ppn;
  endtask

  // One cycle of stimulus; model sees lookups before same-cycle writes (R12)
  task automatic step(input bit lv, input logic [31:0] va,
                      input bit rv, input logic [23:0] rvpn, input logic [7:0] rasid,
                      input logic [23:0] rppn,
                      input bit iv, input logic [1:0] iop, input int iidx,
                      input logic [7:0] iasid, input string tag);
    @(negedge clk);
    lookupValid = lv; lookupVaddr = va;
    refillValid = rv; refillVpn = rvpn; refillAsid = rasid; refillPpn = rppn;
    invValid = iv; invOp = iop; invIndex = 3'(iidx); invAsid = iasid;
    if (lv) expectLookup(va, tag);
    if (iv) modelInv(iop, iidx, iasid);
    if (rv) modelRefill(rvpn, rasid, rppn);
  endtask

  task automatic lookup(input logic [31:0] va, input string tag);
    step(1, va, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic refill(input logic [23:0] vpn, input logic [7:0] asid, input logic [23:0] ppn);
    step(0, 0, 1, vpn, asid, ppn, 0, 0, 0, 0, "");
  endtask
  task automatic inval(input logic [1:0] op, input int idx, input logic [7:0] asid);
    step(0, 0, 0, 0, 0, 0, 1, op, idx, asid, "");
  endtask
  task automatic setCtx(input logic [7:0] pid, input bit en);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    curPid = pid;
    mmuEnable = en;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (qHit.size() == 0) begin
        check(1'b0, "R2", "unexpected respValid", 32'd1, 32'd0);
      end else begin
        logic eh, ew;
        logic [31:0] ep;
        logic [23:0] ev;
        string t;
        eh = qHit.pop_front(); ep = qPa.pop_front(); ew = qWalk.pop_front();
        ev = qWvpn.pop_front(); t = qTag.pop_front();
        check(respHit === eh && respPaddr === ep && walkReq === ew &&
              (!ew || walkVpn === ev), t, "hit/paddr/walk",
              {respHit, walkReq, respPaddr[29:0]}, {eh, ew, ep[29:0]});
        if (ew) check(walkVpn === ev, t, "walkVpn", {8'h0, walkVpn}, {8'h0, ev});
      end
    end
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) begin
      mV[i] = 1'b0; mVpn[i] = '0; mAsid[i] = '0; mPpn[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(respValid === 1'b0 && respHit === 1'b0 && walkReq === 1'b0, "R1",
          "reset outputs", {29'h0, respValid, respHit, walkReq}, 32'h0);
    setCtx(8'd1, 1'b1);
    lookup(32'h0000_0123, "R1");
    refill(24'h0, 8'd1, 24'h40_0005);
    lookup(32'h0000_0123, "R4");
    setCtx(8'd2, 1'b1);
    lookup(32'h0000_0045, "R5");
    lookup(32'h00AB_CD10, "R6");
    refill(24'h0, 8'd2, 24'h40_0000);
    lookup(32'h0000_0045, "R5");
    setCtx(8'd1, 1'b1);
    lookup(32'h0000_0123, "R5");
    // R3 bypass
    setCtx(8'd1, 1'b0);
    lookup(32'h0000_0123, "R3");
    lookup(32'h1234_5678, "R3");
    setCtx(8'd1, 1'b1);
    lookup(32'hE000_1234, "R3");
    lookup(32'hFFFF_FFFF, "R3");
    // R7 fill the buffer
    for (int i = 1; i <= 6; i++) refill(24'(i), 8'd3, 24'(32'h100 + i));
    setCtx(8'd3, 1'b1);
    for (int i = 1; i <= 6; i++) lookup({24'(i), 8'(i)}, "R7");
    refill(24'h2, 8'd3, 24'h777);
    lookup(32'h0000_0205, "R7");
    lookup(32'h0000_0301, "R7");
    // R8 round-robin eviction
    refill(24'h7, 8'd3, 24'h207);
    lookup(32'h0000_0799, "R8");
    setCtx(8'd1, 1'b1);
    lookup(32'h0000_0010, "R8");
    setCtx(8'd2, 1'b1);
    lookup(32'h0000_0010, "R8");
    refill(24'h8, 8'd2, 24'h208);
    lookup(32'h0000_0010, "R8");
    lookup(32'h0000_0810, "R8");
    // R11 op 0 has no effect
    inval(2'd0, 1, 8'd2);
    lookup(32'h0000_0810, "R11");
    // R9 single slot
    inval(2'd1, 1, 8'd0);
    lookup(32'h0000_0810, "R9");
    setCtx(8'd3, 1'b1);
    lookup(32'h0000_0105, "R9");
    // R7 free slot preferred, then R8 resumes
    refill(24'h9, 8'd3, 24'h209);
    refill(24'hA, 8'd3, 24'h20A);
    lookup(32'h0000_0900, "R7");
    lookup(32'h0000_0100, "R8");
    lookup(32'h0000_0A00, "R8");
    lookup(32'h0000_0700, "R8");
    // R10 by tag
    refill(24'h55, 8'd1, 24'h355);
    inval(2'd2, 0, 8'd3);
    for (int i = 2; i <= 10; i++) lookup({24'(i), 8'h11}, "R10");
    setCtx(8'd1, 1'b1);
    lookup(32'h0000_5501, "R10");
    // R12 same-cycle refill and lookup
    step(1, 32'h0000_6600, 1, 24'h66, 8'd1, 24'h366, 0, 0, 0, 0, "R12");
    lookup(32'h0000_6600, "R12");
    // R12 same-cycle flush and lookup, then R11 flush effect
    step(1, 32'h0000_5501, 0, 0, 0, 0, 1, 2'd3, 0, 0, "R12");
    lookup(32'h0000_5501, "R11");
    lookup(32'h0000_6600, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    repeat (3) @(negedge clk);
    check(qHit.size() == 0, "R2", "responses outstanding", qHit.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule